// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a chain of identical 4-bit synchronous up-counter stages. Every stage can be preset from a parallel data word, and every stage can be cleared at once by an active-low asynchronous reset. Each stage has two count enables. A stage advances only when both enables are high. Its terminal-count flag is qualified by only one of them, the trickle enable.

The wrapper links the stages in look-ahead fashion. The terminal-count flag of each stage drives the trickle enable of the stage above it. All stages share the parallel enable, the load strobe, the clock and the reset. With this wiring, N stages form one binary counter of N×4 bits. That counter can be preset as a whole, held with either enable, and cascaded further through the flag of the top stage.

Top module: `cnt_chain`

## Requirements
- R1: While `rst_n` is low, every bit of `q` is 0 immediately, without waiting for a clock edge. This overrides the clock, `load_n` and both enables.
- R2: When `load_n` is low at a rising clock edge, `q` takes the value of `din`. Stage k takes bits [4k+3:4k].
- R3: The load of R2 takes place whatever the levels of `en_par` and `en_trk`.
- R4: When `load_n` is high, a stage increments by one at a rising edge only if `en_par` and that stage's trickle enable are both high.
- R5: When `load_n` is high and either enable of a stage is low, that stage holds its value.
- R6: A stage that counts at the value 15 becomes 0 (wrap).
- R7: A stage's terminal-count flag `tc[k]` is high exactly when its trickle enable is high and its count is 15. `en_par` has no effect on it.
- R8: The trickle enable of stage 0 is `en_trk`, and that of stage k>0 is `tc[k-1]`. The whole chain therefore behaves as one binary counter of N×4 bits, with bit 0 the least significant.
- R9: After `rst_n` is released away from a clock edge, counting resumes from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| rst_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Parallel count enable, common to all stages |
| en_trk | input | 1 | Trickle enable of stage 0 |
| din | input | STAGES*W | Preset data, stage k in bits [W*k+W-1:W*k] |
| q | output | STAGES*W | Concatenated stage counts |
| tc | output | STAGES | Terminal-count flag of each stage |

## Verification
The chain is driven through several patterns:
- Holds with only the parallel enable low and with only the trickle enable low. These show that either enable alone freezes the count, and that only the trickle enable gates the flag.
- Loads with both enables low and with both enables high. These show that the preset wins over counting.
- Long count runs that cross the low-stage wrap and the full 8-bit wrap. These expose carry and terminal-count errors between stages.
- A reset asserted in the middle of a cycle while a load is pending. This tells the asynchronous clear apart from a synchronous one, and confirms that counting restarts from zero.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output cnt_op_e op
);

    // Load has priority over counting; either enable low means hold.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_trk) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         en_par,
    input  logic         en_trk,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    cnt_op_e op;
    stage_t  st_d;
    stage_t  st_q;

    cnt_op_decode u_dec (
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = st_q.cnt + ONE;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q  = st_q.cnt;
    // Flag is combinational so the next stage sees it within the same cycle.
    assign tc = en_trk && (st_q.cnt == FULL);

    // R2 and R3: preset lands whatever the enables are.
    a_r2_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));

    // R4: increment only with both enables high.
    a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk) |=> q == $past(q) + ONE);

    // R5: either enable low freezes the stage.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    // R6: all-ones wraps to zero.
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk && q == FULL) |=> q == '0);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int STAGES = 2,
    parameter int W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_n,
    input  logic                en_par,
    input  logic                en_trk,
    input  logic [STAGES*W-1:0] din,
    output logic [STAGES*W-1:0] q,
    output logic [STAGES-1:0]   tc
);

    logic [STAGES-1:0] trk_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign trk_in[k] = en_trk;
        end else begin : g_link
            assign trk_in[k] = tc[k-1];

            // R8: an upper stage never moves unless the one below it carries.
            a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (load_n && !tc[k-1]) |=> $stable(q[W*k +: W]));

            // R8: a stage can only flag terminal count if the stage below does.
            a_r8_tc_nested: assert property (@(posedge clk) disable iff (!rst_n)
                tc[k] |-> tc[k-1]);
        end

        cnt_stage #(.W(W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (load_n),
            .en_par (en_par),
            .en_trk (trk_in[k]),
            .din    (din[W*k +: W]),
            .q      (q[W*k +: W]),
            .tc     (tc[k])
        );
    end

endmodule

// File: tb/tb_cnt_chain.sv
module tb_cnt_chain;

    localparam int  STAGES = 2;
    localparam int  W      = 4;
    localparam int  TOT    = STAGES * W;
    localparam time PERIOD = 8ns;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              load_n;
    logic              en_par;
    logic              en_trk;
    logic [TOT-1:0]    din;
    logic [TOT-1:0]    q;
    logic [STAGES-1:0] tc;

    int             checks = 0;
    int             fails  = 0;
    bit             done   = 0;
    logic [TOT-1:0] ref_cnt = '0;
    string          tag = "R1";

    always #(PERIOD / 2) clk = ~clk;

    cnt_chain #(.STAGES(STAGES), .W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .din    (din),
        .q      (q),
        .tc     (tc)
    );

    function automatic logic [STAGES-1:0] exp_tc();
        logic [STAGES-1:0] r;
        for (int k = 0; k < STAGES; k++) begin
            logic ok = en_trk;
            for (int j = 0; j < (k + 1) * W; j++) ok &= ref_cnt[j];
            r[k] = ok;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(tag, q, ref_cnt);
        chk({tag, " R7 tc"}, TOT'(tc), TOT'(exp_tc()));
    endtask

    // One clock: behavioural model update at the edge, compare mid-low phase.
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (!rst_n)            ref_cnt = '0;
            else if (!load_n)      ref_cnt = din;
            else if (en_par && en_trk) ref_cnt = ref_cnt + 1'b1;
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        rst_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; din = '0;
        repeat (2) @(negedge clk);
        tag = "R1 reset state";
        compare();
        #1 rst_n = 1'b1;
        tag = "R9";
        cyc(1);

        // R5: parallel enable low holds, trickle high.
        en_trk = 1'b1; tag = "R5 par low";
        cyc(3);
        // R4: both high counts.
        en_par = 1'b1; tag = "R4 count";
        cyc(5);
        // R5: trickle low holds.
        en_trk = 1'b0; tag = "R5 trk low";
        cyc(3);
        // R2/R3: load with enables low.
        en_par = 1'b0; load_n = 1'b0; din = 8'hA5; tag = "R2 R3 load idle";
        cyc(1);
        // R3: load while counting is enabled.
        en_par = 1'b1; en_trk = 1'b1; din = 8'h0B; tag = "R3 load over count";
        cyc(2);
        // R6/R8: cross the low-stage wrap.
        load_n = 1'b1; tag = "R6 R8 carry";
        cyc(20);
        // R7: flag with parallel enable low.
        load_n = 1'b0; din = 8'hFF; tag = "R2 preload";
        cyc(1);
        load_n = 1'b1; en_par = 1'b0; tag = "R7 par ignored";
        cyc(2);
        en_trk = 1'b0; tag = "R7 trk gates";
        cyc(1);
        // R8: full wrap of the cascade.
        load_n = 1'b0; din = 8'hF0; tag = "R2 preload";
        cyc(1);
        load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1; tag = "R6 R8 full wrap";
        cyc(300);
        // R1: reset mid-cycle with a pending load.
        load_n = 1'b0; din = 8'h33;
        #1 rst_n = 1'b0;
        ref_cnt = '0;
        #1 tag = "R1 async clear";
        compare();
        cyc(2);
        load_n = 1'b1;
        #1 rst_n = 1'b1;
        tag = "R9 restart";
        cyc(6);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule